// File: doc/BRIEF.md
# Compare-Driven PWM Generator

This block produces two pulse-width-modulated outputs from one signed 16-bit up-counter. The counter starts each period at a programmable start value and counts up to a programmable end value, then starts over. A mid-point compare marks half a cycle. Each output has its own pair of compare values. The output turns on when the counter reaches its "on" value and turns off when the counter reaches its "off" value. Because all values are two's-complement, both plain unsigned ranges (0..P) and ranges centred on zero (-P/2..P/2) work. Edge-aligned and centre-aligned waveforms follow only from how software places the compare values.

The two outputs can run as independent channels, or as a complementary pair driven from either output. Each pin has its own polarity and enable. The counter clock is divided by a power of two.

The seven compare values are double-buffered. Software writes them into shadow registers and then sets a load-ready flag. The shadow values move into the working set under a selectable policy: at once, at the mid-point, at the period end, or at either point. The transfer can also be restricted to every Nth such opportunity.

Configuration is through a simple write-only register port.

Top module: `pwm_cmp_gen`

## Requirements
- R1: After reset both outputs are low, the control word is zero and all compare values are zero.
- R2: While running, the counter advances from the working start value up to the working end value (register 2) and then reloads the start value, so one period is (end - start + 1) counts.
- R3: The counter advances once every 2^k clocks, with k in control bits [2:0], and holds its value between advances.
- R4: Output A's raw level sets when the counter equals the A-on value (register 3) and clears when it equals the A-off value (register 4). The clear wins, so equal on and off values keep the output inactive for the whole period. Output B does the same with registers 5 and 6.
- R5: Start, mid, end and edge values are compared as signed 16-bit numbers, so negative start values and negative edges give the same duty as their shifted unsigned equivalents.
- R6: With control bit 8 set, the two outputs form a complementary pair. Control bit 9 picks the source: 0 means A drives and B is the inverse of A's raw level; 1 means B drives and A is the inverse of B's raw level.
- R7: Control bits 10 and 11 make A and B low-true (inverted). Control bits 12 and 13 enable A and B. A disabled pin is held low. Control bit 15 runs the counter; while it is clear the counter sits at the start value and both raw levels are low.
- R8: Writes to addresses 0..6 (start, mid, end, A-on, A-off, B-on, B-off) only fill shadow registers and do not change the waveform. Writing 1 to bit 0 of address 8 sets the load-ready flag. In immediate mode (control bits [4:3] = 0) the shadow set is copied to the working set on the next clock and the flag clears.
- R9: In reload mode 1 the copy happens when the counter advances at the mid value. In mode 2 it happens when the counter advances at the end value. In mode 3 it happens at either point. Address 7 is the control word, and it takes effect at once.
- R10: Control bits [7:5] hold N-1. The copy happens only on the Nth opportunity counted from when the load-ready flag was set. In immediate mode this field has no effect.
- R11: While the load-ready flag is set, writes to addresses 0..6 are ignored. Once a copy clears the flag, writes are accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0..6 shadow compare, 7 control, 8 load-ready) |
| wr_data | input | 16 | Write data |
| pwm_a | output | 1 | Output A pin |
| pwm_b | output | 1 | Output B pin |

## Verification
The assertions assume the working end value is reachable from the start value by counting up, and that software stops the counter (control bit 15 clear) before installing a range that the current count may already have passed. Otherwise the count would have to run all the way round the 16-bit space before it wraps. The stimulus keeps to this: every new range is loaded with the counter stopped, random ranges are short and ordered start below end, and reload-timing tests change only the A-off edge inside a fixed range. The load-ready flag is raised early in a period, so the half-cycle and full-cycle opportunities fall in a known order.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
    parameter int CNT_W  = 16;
    parameter int PSC_W  = 3;
    parameter int FRQ_W  = 3;
    parameter int ADDR_W = 4;

    typedef logic signed [CNT_W-1:0] cval_t;

    typedef struct packed {
        cval_t start;
        cval_t mid;
        cval_t fin;
        cval_t a_on;
        cval_t a_off;
        cval_t b_on;
        cval_t b_off;
    } cmp_set_t;

    typedef enum logic [1:0] {
        RL_IMM  = 2'd0,
        RL_HALF = 2'd1,
        RL_FULL = 2'd2,
        RL_BOTH = 2'd3
    } rl_mode_t;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(7);
    localparam logic [ADDR_W-1:0] A_LDOK = ADDR_W'(8);

    localparam int C_PSC  = 0;
    localparam int C_MODE = 3;
    localparam int C_FRQ  = 5;
    localparam int C_COMP = 8;
    localparam int C_SRCB = 9;
    localparam int C_POLA = 10;
    localparam int C_POLB = 11;
    localparam int C_ENA  = 12;
    localparam int C_ENB  = 13;
    localparam int C_RUN  = 15;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PW = pwm_cmp_pkg::PSC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] k,
    output logic          tick
);
    localparam int DW = (1 << PW) - 1;

    typedef struct packed {
        logic [DW-1:0] div;
    } psc_st_t;

    psc_st_t st_q, st_d;
    logic [DW:0] lim;

    always_comb begin
        st_d = st_q;
        lim  = ((DW+1)'(1) << k) - (DW+1)'(1);
        tick = run && ({1'b0, st_q.div} >= lim);
        if (!run || tick) begin
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
    import pwm_cmp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int FW = FRQ_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  cval_t            wr_data,
    input  logic             half_opp,
    input  logic             full_opp,
    input  rl_mode_t         mode,
    input  logic [FW-1:0]    every,
    output cmp_set_t         act,
    output cmp_set_t         act_nxt,
    output cmp_set_t         shd,
    output logic             ldok
);
    typedef struct packed {
        cmp_set_t      shd;
        cmp_set_t      act;
        logic          ldok;
        logic [FW-1:0] opp;
    } shd_st_t;

    shd_st_t st_q, st_d;
    logic    opp_hit;
    logic    reload;

    always_comb begin
        st_d    = st_q;
        opp_hit = (mode[0] & half_opp) | (mode[1] & full_opp);
        reload  = st_q.ldok && ((mode == RL_IMM) || (opp_hit && (st_q.opp == every)));

        if (reload) begin
            st_d.act  = st_q.shd;
            st_d.ldok = 1'b0;
            st_d.opp  = '0;
        end else if (st_q.ldok && opp_hit) begin
            st_d.opp = st_q.opp + 1'b1;
        end

        if (wr_en && !st_q.ldok) begin
            case (wr_addr)
                AW'(0):  st_d.shd.start = wr_data;
                AW'(1):  st_d.shd.mid   = wr_data;
                AW'(2):  st_d.shd.fin   = wr_data;
                AW'(3):  st_d.shd.a_on  = wr_data;
                AW'(4):  st_d.shd.a_off = wr_data;
                AW'(5):  st_d.shd.b_on  = wr_data;
                AW'(6):  st_d.shd.b_off = wr_data;
                default: ;
            endcase
        end

        if (wr_en && (wr_addr == A_LDOK) && wr_data[0]) begin
            st_d.ldok = 1'b1;
            st_d.opp  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act     = st_q.act;
    assign act_nxt = st_d.act;
    assign shd     = st_q.shd;
    assign ldok    = st_q.ldok;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_cmp_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     tick,
    input  cmp_set_t act,
    input  cmp_set_t act_nxt,
    output cval_t    cnt,
    output logic     raw_a,
    output logic     raw_b,
    output logic     half_opp,
    output logic     full_opp
);
    typedef struct packed {
        cval_t          cnt;
        logic [NCH-1:0] raw;
    } tb_st_t;

    tb_st_t st_q, st_d;
    cval_t  on_v  [NCH];
    cval_t  off_v [NCH];

    always_comb begin
        on_v[0]  = act.a_on;
        off_v[0] = act.a_off;
        on_v[1]  = act.b_on;
        off_v[1] = act.b_off;
    end

    always_comb begin
        st_d     = st_q;
        half_opp = run && tick && (st_q.cnt == act.mid);
        full_opp = run && tick && (st_q.cnt == act.fin);
        if (!run) begin
            st_d.cnt = act_nxt.start;
            st_d.raw = '0;
        end else begin
            if (tick) begin
                if (st_q.cnt == act.fin) begin
                    st_d.cnt = act_nxt.start;
                end else begin
                    st_d.cnt = st_q.cnt + cval_t'(1);
                end
            end
            for (int ch = 0; ch < NCH; ch++) begin
                if (st_q.cnt == off_v[ch]) begin
                    st_d.raw[ch] = 1'b0;
                end else if (st_q.cnt == on_v[ch]) begin
                    st_d.raw[ch] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt   = st_q.cnt;
    assign raw_a = st_q.raw[0];
    assign raw_b = st_q.raw[1];
endmodule

// File: rtl/pwm_cmp_gen.sv
module pwm_cmp_gen
    import pwm_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              pwm_a,
    output logic              pwm_b
);
    typedef struct packed {
        logic [CNT_W-1:0] ctrl;
    } top_st_t;

    top_st_t          st_q, st_d;
    logic             run, tick, comp, src_b, pol_a, pol_b, en_a, en_b;
    logic [PSC_W-1:0] psc;
    logic [FRQ_W-1:0] every;
    rl_mode_t         mode;
    cmp_set_t         act, act_nxt, shd;
    logic             ldok;
    cval_t            cnt;
    logic             raw_a, raw_b, half_opp, full_opp;
    logic             lvl_a, lvl_b;

    always_comb begin
        st_d = st_q;
        if (wr_en && (wr_addr == A_CTRL)) begin
            st_d.ctrl = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign psc   = st_q.ctrl[C_PSC +: PSC_W];
    assign mode  = rl_mode_t'(st_q.ctrl[C_MODE +: 2]);
    assign every = st_q.ctrl[C_FRQ +: FRQ_W];
    assign comp  = st_q.ctrl[C_COMP];
    assign src_b = st_q.ctrl[C_SRCB];
    assign pol_a = st_q.ctrl[C_POLA];
    assign pol_b = st_q.ctrl[C_POLB];
    assign en_a  = st_q.ctrl[C_ENA];
    assign en_b  = st_q.ctrl[C_ENB];
    assign run   = st_q.ctrl[C_RUN];

    pwm_prescaler #(.PW(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .k     (psc),
        .tick  (tick)
    );

    pwm_shadow #(.AW(ADDR_W), .FW(FRQ_W)) u_shd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (cval_t'(wr_data)),
        .half_opp (half_opp),
        .full_opp (full_opp),
        .mode     (mode),
        .every    (every),
        .act      (act),
        .act_nxt  (act_nxt),
        .shd      (shd),
        .ldok     (ldok)
    );

    pwm_timebase #(.NCH(2)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .act      (act),
        .act_nxt  (act_nxt),
        .cnt      (cnt),
        .raw_a    (raw_a),
        .raw_b    (raw_b),
        .half_opp (half_opp),
        .full_opp (full_opp)
    );

    // Pair routing, then per-pin polarity and enable.
    always_comb begin
        lvl_a = raw_a;
        lvl_b = raw_b;
        if (comp) begin
            if (src_b) begin
                lvl_a = ~raw_b;
            end else begin
                lvl_b = ~raw_a;
            end
        end
        pwm_a = en_a & (lvl_a ^ pol_a);
        pwm_b = en_b & (lvl_b ^ pol_b);
    end
endmodule

// File: rtl/pwm_cmp_gen_chk.sv
module pwm_cmp_gen_chk
    import pwm_cmp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              run,
    input logic              tick,
    input cval_t             cnt,
    input cmp_set_t          act,
    input cmp_set_t          shd,
    input logic              ldok,
    input rl_mode_t          mode,
    input logic              raw_a,
    input logic              comp,
    input logic              en_a,
    input logic              en_b,
    input logic              pol_a,
    input logic              pol_b,
    input logic              pwm_a,
    input logic              pwm_b
);
    AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && cnt == act.fin) |=> (cnt == act.start)); // R2

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (!run || $stable(cnt))); // R3

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == act.a_off) |=> !raw_a); // R4

    AST_PAIR_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
        (comp && en_a && en_b && (pol_a == pol_b)) |-> (pwm_a != pwm_b)); // R6

    AST_IMM_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ldok && mode == RL_IMM && !(wr_en && wr_addr == A_LDOK)) |=> !ldok); // R8

    AST_SHADOW_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ldok && wr_en && wr_addr < A_CTRL) |=> $stable(shd)); // R11
endmodule

bind pwm_cmp_gen pwm_cmp_gen_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .run     (run),
    .tick    (tick),
    .cnt     (cnt),
    .act     (act),
    .shd     (shd),
    .ldok    (ldok),
    .mode    (mode),
    .raw_a   (raw_a),
    .comp    (comp),
    .en_a    (en_a),
    .en_b    (en_b),
    .pol_a   (pol_a),
    .pol_b   (pol_b),
    .pwm_a   (pwm_a),
    .pwm_b   (pwm_b)
);

// File: tb/pwm_cmp_gen_tb.sv
`timescale 1ns/1ps
module pwm_cmp_gen_tb;
    import pwm_cmp_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_a, pwm_b;
    int          tests = 0;
    int          failed = 0;
    bit          done = 1'b0;

    pwm_cmp_gen u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_a   (pwm_a),
        .pwm_b   (pwm_b)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string tag, int got, int exp);
        tests++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Raw-level high counts per period, one count per counter value.
    function automatic int hi_counts(int s, int e, int on, int off);
        int raw = 0;
        int hi = 0;
        for (int p = 0; p < 2; p++) begin
            for (int c = s; c <= e; c++) begin
                if (c == off) raw = 0;
                else if (c == on) raw = 1;
                if (p == 1 && raw == 1) hi++;
            end
        end
        return hi;
    endfunction

    function automatic logic [15:0] mkctrl(int k, rl_mode_t m, int f, bit cmp, bit srcb,
                                           bit pa, bit pb, bit ea, bit eb, bit rn);
        logic [15:0] c = '0;
        c[2:0]  = 3'(k);
        c[4:3]  = m;
        c[7:5]  = 3'(f);
        c[8]    = cmp;
        c[9]    = srcb;
        c[10]   = pa;
        c[11]   = pb;
        c[12]   = ea;
        c[13]   = eb;
        c[15]   = rn;
        return c;
    endfunction

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(int s, int m, int e, int ao, int af, int bo, int bf, logic [15:0] ctl);
        wr(7, int'(ctl & ~16'h8018));
        wr(0, s); wr(1, m); wr(2, e);
        wr(3, ao); wr(4, af); wr(5, bo); wr(6, bf);
        wr(8, 1);
        wr(7, int'(ctl));
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic win(int n, output int ha, output int hb, output int ne);
        ha = 0; hb = 0; ne = 0;
        repeat (n) begin
            @(negedge clk);
            ha += int'(pwm_a);
            hb += int'(pwm_b);
            ne += int'(pwm_a != pwm_b);
        end
    endtask

    task automatic next_pulse(output int w);
        w = 0;
        while (pwm_a === 1'b1) @(negedge clk);
        while (pwm_a === 1'b0) @(negedge clk);
        while (pwm_a === 1'b1) begin w++; @(negedge clk); end
    endtask

    task automatic period_of(output int p);
        p = 0;
        while (pwm_a === 1'b1) @(negedge clk);
        while (pwm_a === 1'b0) @(negedge clk);
        while (pwm_a === 1'b1) begin p++; @(negedge clk); end
        while (pwm_a === 1'b0) begin p++; @(negedge clk); end
    endtask

    task automatic wait_rise();
        while (pwm_a === 1'b1) @(negedge clk);
        while (pwm_a === 1'b0) @(negedge clk);
    endtask

    // Range 0..19, A pulse 6 wide; A-off changed to 12 with the given policy.
    task automatic reload_case(rl_mode_t m, int f, int first_new, string tag);
        int w;
        load(0, 10, 19, 0, 6, 0, 6, mkctrl(0, m, f, 0, 0, 0, 0, 1, 0, 1));
        settle(45);
        wait_rise();
        wr(4, 12);
        wr(8, 1);
        for (int i = 1; i <= 3; i++) begin
            next_pulse(w);
            chk(tag, w, (i >= first_new) ? 12 : 6);
        end
    endtask

    initial begin
        #900000;
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        int ha, hb, ne, w, p;
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle(3);
        chk("R1 reset pwm_a", int'(pwm_a), 0);
        chk("R1 reset pwm_b", int'(pwm_b), 0);

        // Edge-aligned 0..19, A on 0 off 7
        load(0, 10, 19, 0, 7, 0, 7, mkctrl(0, RL_IMM, 0, 0, 0, 0, 0, 1, 1, 1));
        settle(40);
        win(80, ha, hb, ne);
        chk("R4 edge duty A", ha, 4 * hi_counts(0, 19, 0, 7));
        chk("R4 edge duty B", hb, 28);
        period_of(p);
        chk("R2 period", p, 20);
        next_pulse(w);
        chk("R4 pulse width", w, 7);

        // Prescale divide by 4
        load(0, 10, 19, 0, 7, 0, 7, mkctrl(2, RL_IMM, 0, 0, 0, 0, 0, 1, 1, 1));
        settle(160);
        period_of(p);
        chk("R3 prescaled period", p, 80);
        next_pulse(w);
        chk("R3 prescaled width", w, 28);

        // Signed centre-aligned -10..9, edges -3/+3
        load(-10, 0, 9, -3, 3, -4, 4, mkctrl(0, RL_IMM, 0, 0, 0, 0, 0, 1, 1, 1));
        settle(40);
        win(80, ha, hb, ne);
        chk("R5 signed centre A", ha, 4 * 6);
        chk("R5 signed centre B", hb, 4 * 8);

        // Equal on/off stays inactive
        load(0, 10, 19, 5, 5, 0, 7, mkctrl(0, RL_IMM, 0, 0, 0, 0, 0, 1, 1, 1));
        settle(40);
        win(80, ha, hb, ne);
        chk("R4 equal edges inactive", ha, 0);

        // Polarity and enable
        load(0, 10, 19, 0, 7, 0, 7, mkctrl(0, RL_IMM, 0, 0, 0, 1, 0, 1, 0, 1));
        settle(40);
        win(80, ha, hb, ne);
        chk("R7 low-true A", ha, 80 - 28);
        chk("R7 disabled B", hb, 0);

        // Complementary, A source
        load(0, 10, 19, 0, 7, 2, 14, mkctrl(0, RL_IMM, 0, 1, 0, 0, 0, 1, 1, 1));
        settle(40);
        win(80, ha, hb, ne);
        chk("R6 pair A source A", ha, 28);
        chk("R6 pair A source B", hb, 52);
        chk("R6 pair opposite", ne, 80);
        // Complementary, B source
        wr(7, int'(mkctrl(0, RL_IMM, 0, 1, 1, 0, 0, 1, 1, 1)));
        settle(40);
        win(80, ha, hb, ne);
        chk("R6 pair B source B", hb, 48);
        chk("R6 pair B source A", ha, 32);

        // Random signed ranges
        for (int i = 0; i < 6; i++) begin
            int k, len, s, e, ao, af, bo, bf;
            k   = int'($urandom % 3);
            len = 8 + int'($urandom % 24);
            s   = -int'($urandom % 20);
            e   = s + len - 1;
            ao  = s + int'($urandom % len);
            af  = s + int'($urandom % len);
            bo  = s + int'($urandom % len);
            bf  = s + int'($urandom % len);
            load(s, s, e, ao, af, bo, bf, mkctrl(k, RL_IMM, 0, 0, 0, 0, 0, 1, 1, 1));
            settle(2 * (len << k));
            win(3 * (len << k), ha, hb, ne);
            chk("R5 R2 random A", ha, 3 * (hi_counts(s, e, ao, af) << k));
            chk("R5 R2 random B", hb, 3 * (hi_counts(s, e, bo, bf) << k));
        end

        // Shadow write without load-ready has no effect
        load(0, 10, 19, 0, 6, 0, 6, mkctrl(0, RL_FULL, 0, 0, 0, 0, 0, 1, 0, 1));
        settle(45);
        wr(4, 14);
        next_pulse(w);
        chk("R8 shadow only", w, 6);
        next_pulse(w);
        chk("R8 shadow only later", w, 6);

        reload_case(RL_IMM,  2, 1, "R8 R10 immediate ignores N");
        reload_case(RL_FULL, 0, 1, "R9 full every");
        reload_case(RL_HALF, 0, 1, "R9 half every");
        reload_case(RL_BOTH, 1, 1, "R9 both second opportunity");
        reload_case(RL_FULL, 2, 3, "R10 full third");
        reload_case(RL_HALF, 1, 2, "R10 half second");
        reload_case(RL_BOTH, 2, 2, "R10 both third");

        // Writes ignored while load-ready pending, accepted after it clears
        load(0, 10, 19, 0, 6, 0, 6, mkctrl(0, RL_FULL, 2, 0, 0, 0, 0, 1, 0, 1));
        settle(45);
        wait_rise();
        wr(4, 12);
        wr(8, 1);
        wr(4, 16);
        next_pulse(w);
        chk("R11 pending pulse1", w, 6);
        next_pulse(w);
        chk("R11 pending pulse2", w, 6);
        next_pulse(w);
        chk("R11 locked write ignored", w, 12);
        wr(7, int'(mkctrl(0, RL_IMM, 0, 0, 0, 0, 0, 1, 0, 1)));
        wr(4, 9);
        wr(8, 1);
        next_pulse(w);
        next_pulse(w);
        chk("R11 write accepted after clear", w, 9);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule